// File: doc/BRIEF.md
# Descriptor-Driven Successive DMA Engine

This block is a single-master DMA engine whose channel settings live in memory as three-word descriptors rather than in registers. A trigger on a channel, tagged as hardware or software, makes the engine fetch that channel's descriptor from an address computed from a base value and the channel number. In successive mode it then copies one unit after another from the source to the destination until the unit count is exhausted. Finally it stores the updated descriptor back to memory and settles that channel's interrupt flag and enable bit.

Triggers that arrive while a descriptor is being processed are held as pending. The lowest-numbered pending channel is served next. Memory is reached through a plain request/acknowledge master port. Units of one, two or four bytes travel right-aligned on the data buses.

Top module: `desc_dma_seq`

## Requirements
- R1: On a trigger for channel c, the engine reads three 32-bit words, in ascending order, at base + 12*c, base + 12*c + 4 and base + 12*c + 8.
- R2: Descriptor word 0 bits [29:28] hold the mode. Only the value 01 moves data. Any other value ends the run after the three loads, with no data access, no descriptor store and no flag change.
- R3: The count in word 0 bits [CW-1:0] gives the number of units moved by a single trigger. The count is lowered by one after each unit written.
- R4: Word 0 bits [25:24] select the unit size: 00 is a byte, 01 is a halfword, 10 or 11 is a word. Words 1 and 2 carry the source and destination address in bits [AW-1:0] and a step code in bits [29:28]: 01 increments, 10 decrements, anything else holds the address. The step equals the unit size.
- R5: After the last unit, the three descriptor words are written back to the same addresses in the same order. They carry a zero count and the final addresses, and every other bit is unchanged.
- R6: A count of zero at load time moves no data. The descriptor is still written back and the completion flag handling still takes place.
- R7: When a hardware-triggered run completes and word 0 bit 26 is 1, the channel's interrupt flag stays set and its enable bit is cleared.
- R8: When a hardware-triggered run completes and word 0 bit 26 is 0, the channel's interrupt flag is cleared and its enable bit is kept.
- R9: An accepted hardware trigger sets the channel's interrupt flag. A hardware trigger on a channel whose enable bit is clear is ignored. A software trigger is always accepted and leaves flag and enable untouched.
- R10: A halfword address with bit 0 set, or a word address with bits [1:0] nonzero, aborts the run before any data access. The abort pulses err_o for one cycle and skips the descriptor store and flag handling.
- R11: Triggers accepted while busy are kept pending per channel. The lowest pending channel number is served first.
- R12: A memory request keeps its address and direction stable until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | NCH | Per-channel trigger pulse |
| trig_hw_i | input | NCH | Trigger tag: 1 hardware, 0 software |
| en_set_i | input | NCH | Sets channel enable bits |
| base_addr_i | input | AW | Descriptor table base address |
| mreq_o | output | 1 | Memory request |
| mwe_o | output | 1 | Memory write when 1, read when 0 |
| maddr_o | output | AW | Memory byte address |
| msize_o | output | 2 | Access size code (00 byte, 01 half, 1x word) |
| mwdata_o | output | 32 | Write data, right-aligned |
| mack_i | input | 1 | Memory acknowledge, read data valid |
| mrdata_i | input | 32 | Read data, right-aligned |
| busy_o | output | 1 | A descriptor is being processed |
| irq_flag_o | output | NCH | Per-channel interrupt flag |
| chan_en_o | output | NCH | Per-channel enable bits |
| err_o | output | 1 | One-cycle pulse on misalignment abort |

## Verification
The bench builds the engine with four channels, a 16-bit address and an 8-bit count. These values let every channel's descriptor sit in a 1 KB memory model, and each unit size, step direction and count end fit into a few hundred cycles. Four channels are enough to fire two triggers in the same cycle at the far ends of the priority order. They also leave one channel disabled while the others run, for the ignored-trigger case.

// File: rtl/dd_pkg.sv
package dd_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_LOAD, S_CHECK, S_READ, S_WRITE, S_STORE, S_FIN
   } dd_state_e;

   localparam logic [1:0] MODE_SUCC = 2'b01;
   localparam logic [1:0] SZ_BYTE   = 2'b00;
   localparam logic [1:0] SZ_HALF   = 2'b01;
   localparam logic [1:0] SZ_WORD   = 2'b10;
   localparam logic [1:0] STEP_INC  = 2'b01;
   localparam logic [1:0] STEP_DEC  = 2'b10;

   localparam int MODE_LSB  = 28;
   localparam int DINT_BIT  = 26;
   localparam int SIZE_LSB  = 24;
   localparam int CODE_LSB  = 28;
endpackage

// File: rtl/dd_trig_pend.sv
module dd_trig_pend
   import dd_pkg::*;
#(
   parameter int NCH = 4,
   parameter int CHW = 2,
   parameter logic [NCH-1:0] EN_INIT = '1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] trig_i,
   input  logic [NCH-1:0] trig_hw_i,
   input  logic [NCH-1:0] en_set_i,
   input  logic           take_i,
   input  logic           fin_i,
   input  logic [CHW-1:0] fin_ch_i,
   input  logic           fin_hw_i,
   input  logic           fin_dinten_i,
   output logic           pend_any_o,
   output logic [CHW-1:0] grant_ch_o,
   output logic           grant_hw_o,
   output logic [NCH-1:0] flag_o,
   output logic [NCH-1:0] en_o
);
   logic [NCH-1:0] pend_q, pend_hw_q, flag_q, en_q;
   logic [NCH-1:0] acc_hw, acc, gnt_oh, clr_oh, fin_oh;

   assign acc_hw = trig_i & trig_hw_i & en_q;
   assign acc    = (trig_i & ~trig_hw_i) | acc_hw;
   assign gnt_oh = pend_q & (~pend_q + 1'b1);
   assign clr_oh = take_i ? gnt_oh : '0;
   assign fin_oh = fin_i ? (NCH'(1) << fin_ch_i) : '0;

   always_comb begin
      grant_ch_o = '0;
      for (int i = NCH - 1; i >= 0; i--)
         if (gnt_oh[i]) grant_ch_o = CHW'(i);
   end

   assign grant_hw_o = |(gnt_oh & pend_hw_q);
   assign pend_any_o = |pend_q;
   assign flag_o     = flag_q;
   assign en_o       = en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= '0;
         pend_hw_q <= '0;
         flag_q    <= '0;
         en_q      <= EN_INIT;
      end else begin
         pend_q    <= (pend_q & ~clr_oh) | acc;
         pend_hw_q <= (pend_hw_q & ~clr_oh) | acc_hw;
         flag_q    <= (flag_q & ~((fin_hw_i && !fin_dinten_i) ? fin_oh : '0)) | acc_hw;
         en_q      <= (en_q & ~((fin_hw_i && fin_dinten_i) ? fin_oh : '0)) | en_set_i;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_oh)); // R11
   AST_EN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_i && fin_hw_i && fin_dinten_i && !en_set_i[fin_ch_i]) |=> !en_o[$past(fin_ch_i)]); // R7
   AST_SW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_i && !fin_hw_i && trig_i == '0 && en_set_i == '0) |=> (flag_o == $past(flag_o) && en_o == $past(en_o))); // R9
endmodule

// File: rtl/dd_addr_step.sv
module dd_addr_step
   import dd_pkg::*;
#(
   parameter int AW = 24
)(
   input  logic [AW-1:0] addr_i,
   input  logic [1:0]    code_i,
   input  logic [1:0]    size_i,
   output logic [AW-1:0] next_o,
   output logic          misal_o
);
   logic [AW-1:0] nb;

   always_comb begin
      case (size_i)
         SZ_BYTE: begin nb = AW'(1); misal_o = 1'b0;         end
         SZ_HALF: begin nb = AW'(2); misal_o = addr_i[0];    end
         default: begin nb = AW'(4); misal_o = |addr_i[1:0]; end
      endcase
      case (code_i)
         STEP_INC: next_o = addr_i + nb;
         STEP_DEC: next_o = addr_i - nb;
         default:  next_o = addr_i;
      endcase
   end
endmodule

// File: rtl/dd_seq.sv
module dd_seq
   import dd_pkg::*;
#(
   parameter int AW  = 24,
   parameter int CW  = 16,
   parameter int CHW = 2
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pend_any_i,
   input  logic [CHW-1:0] grant_ch_i,
   input  logic           grant_hw_i,
   input  logic [AW-1:0]  base_addr_i,
   output logic           take_o,
   output logic           fin_o,
   output logic [CHW-1:0] fin_ch_o,
   output logic           fin_hw_o,
   output logic           fin_dinten_o,
   output logic           mreq_o,
   output logic           mwe_o,
   output logic [AW-1:0]  maddr_o,
   output logic [1:0]     msize_o,
   output logic [31:0]    mwdata_o,
   input  logic           mack_i,
   input  logic [31:0]    mrdata_i,
   output logic           busy_o,
   output logic           err_o
);
   dd_state_e      st_q;
   logic [CHW-1:0] ch_q;
   logic           hw_q, err_q;
   logic [1:0]     widx_q;
   logic [AW-1:0]  dbase_q;
   logic [31:0]    w0_q, w1_q, w2_q, buf_q, store_w;

   logic [CW-1:0]  cnt;
   logic [1:0]     size, mode;
   logic [AW-1:0]  pt_addr  [2];
   logic [1:0]     pt_code  [2];
   logic [AW-1:0]  pt_next  [2];
   logic           pt_misal [2];

   assign cnt        = w0_q[CW-1:0];
   assign size       = w0_q[SIZE_LSB+1:SIZE_LSB];
   assign mode       = w0_q[MODE_LSB+1:MODE_LSB];
   assign pt_addr[0] = w1_q[AW-1:0];
   assign pt_addr[1] = w2_q[AW-1:0];
   assign pt_code[0] = w1_q[CODE_LSB+1:CODE_LSB];
   assign pt_code[1] = w2_q[CODE_LSB+1:CODE_LSB];

   for (genvar p = 0; p < 2; p++) begin : g_pt
      dd_addr_step #(.AW(AW)) u_step (
         .addr_i (pt_addr[p]),
         .code_i (pt_code[p]),
         .size_i (size),
         .next_o (pt_next[p]),
         .misal_o(pt_misal[p])
      );
   end

   assign take_o       = (st_q == S_IDLE) && pend_any_i;
   assign fin_o        = (st_q == S_FIN);
   assign fin_ch_o     = ch_q;
   assign fin_hw_o     = hw_q;
   assign fin_dinten_o = w0_q[DINT_BIT];
   assign busy_o       = (st_q != S_IDLE);
   assign err_o        = err_q;

   always_comb begin
      case (widx_q)
         2'd0:    store_w = w0_q;
         2'd1:    store_w = w1_q;
         default: store_w = w2_q;
      endcase
      mreq_o   = 1'b0;
      mwe_o    = 1'b0;
      maddr_o  = dbase_q + AW'({widx_q, 2'b00});
      msize_o  = SZ_WORD;
      mwdata_o = store_w;
      case (st_q)
         S_LOAD:  mreq_o = 1'b1;
         S_STORE: begin mreq_o = 1'b1; mwe_o = 1'b1; end
         S_READ:  begin mreq_o = 1'b1; maddr_o = pt_addr[0]; msize_o = size; end
         S_WRITE: begin
            mreq_o = 1'b1; mwe_o = 1'b1; maddr_o = pt_addr[1];
            msize_o = size; mwdata_o = buf_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         ch_q    <= '0;
         hw_q    <= 1'b0;
         err_q   <= 1'b0;
         widx_q  <= '0;
         dbase_q <= '0;
         w0_q    <= '0;
         w1_q    <= '0;
         w2_q    <= '0;
         buf_q   <= '0;
      end else begin
         err_q <= 1'b0;
         case (st_q)
            S_IDLE: if (pend_any_i) begin
               st_q    <= S_LOAD;
               ch_q    <= grant_ch_i;
               hw_q    <= grant_hw_i;
               widx_q  <= '0;
               dbase_q <= base_addr_i + (AW'(grant_ch_i) << 3) + (AW'(grant_ch_i) << 2);
            end
            S_LOAD: if (mack_i) begin
               case (widx_q)
                  2'd0:    w0_q <= mrdata_i;
                  2'd1:    w1_q <= mrdata_i;
                  default: w2_q <= mrdata_i;
               endcase
               widx_q <= widx_q + 2'd1;
               if (widx_q == 2'd2) st_q <= S_CHECK;
            end
            S_CHECK: begin
               widx_q <= '0;
               if (mode != MODE_SUCC)             st_q <= S_IDLE;
               else if (cnt == '0)                st_q <= S_STORE;
               else if (pt_misal[0] || pt_misal[1]) begin
                  st_q  <= S_IDLE;
                  err_q <= 1'b1;
               end else                           st_q <= S_READ;
            end
            S_READ: if (mack_i) begin
               buf_q <= mrdata_i;
               st_q  <= S_WRITE;
            end
            S_WRITE: if (mack_i) begin
               w0_q <= {w0_q[31:CW], cnt - 1'b1};
               w1_q <= {w1_q[31:AW], pt_next[0]};
               w2_q <= {w2_q[31:AW], pt_next[1]};
               st_q <= (cnt == CW'(1)) ? S_STORE : S_READ;
            end
            S_STORE: if (mack_i) begin
               widx_q <= widx_q + 2'd1;
               if (widx_q == 2'd2) st_q <= S_FIN;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_o && !mack_i) |=> (mreq_o && $stable(maddr_o) && $stable(mwe_o))); // R12
   AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_READ) |-> (mode == MODE_SUCC)); // R2
   AST_ZERO_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_CHECK && mode == MODE_SUCC && cnt == '0) |=> (st_q == S_STORE)); // R6
   AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_o && msize_o[1]) |-> (maddr_o[1:0] == 2'b00)); // R10
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_WRITE && mack_i) |=> (cnt == $past(cnt) - 1'b1)); // R3
endmodule

// File: rtl/desc_dma_seq.sv
module desc_dma_seq
   import dd_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 24,
   parameter int CW  = 16,
   parameter logic [NCH-1:0] EN_INIT = '1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] trig_i,
   input  logic [NCH-1:0] trig_hw_i,
   input  logic [NCH-1:0] en_set_i,
   input  logic [AW-1:0]  base_addr_i,
   output logic           mreq_o,
   output logic           mwe_o,
   output logic [AW-1:0]  maddr_o,
   output logic [1:0]     msize_o,
   output logic [31:0]    mwdata_o,
   input  logic           mack_i,
   input  logic [31:0]    mrdata_i,
   output logic           busy_o,
   output logic [NCH-1:0] irq_flag_o,
   output logic [NCH-1:0] chan_en_o,
   output logic           err_o
);
   localparam int CHW = (NCH < 2) ? 1 : $clog2(NCH);

   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("desc_dma_seq: NCH out of range");
   end
   if (AW < 8 || AW > 28) begin : g_bad_aw
      $error("desc_dma_seq: AW must lie in 8..28");
   end
   if (CW < 1 || CW > 24) begin : g_bad_cw
      $error("desc_dma_seq: CW must lie in 1..24");
   end

   logic           pend_any, grant_hw, take, fin, fin_hw, fin_dinten;
   logic [CHW-1:0] grant_ch, fin_ch;

   dd_trig_pend #(.NCH(NCH), .CHW(CHW), .EN_INIT(EN_INIT)) u_pend (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig_i),
      .trig_hw_i   (trig_hw_i),
      .en_set_i    (en_set_i),
      .take_i      (take),
      .fin_i       (fin),
      .fin_ch_i    (fin_ch),
      .fin_hw_i    (fin_hw),
      .fin_dinten_i(fin_dinten),
      .pend_any_o  (pend_any),
      .grant_ch_o  (grant_ch),
      .grant_hw_o  (grant_hw),
      .flag_o      (irq_flag_o),
      .en_o        (chan_en_o)
   );

   dd_seq #(.AW(AW), .CW(CW), .CHW(CHW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .pend_any_i  (pend_any),
      .grant_ch_i  (grant_ch),
      .grant_hw_i  (grant_hw),
      .base_addr_i (base_addr_i),
      .take_o      (take),
      .fin_o       (fin),
      .fin_ch_o    (fin_ch),
      .fin_hw_o    (fin_hw),
      .fin_dinten_o(fin_dinten),
      .mreq_o      (mreq_o),
      .mwe_o       (mwe_o),
      .maddr_o     (maddr_o),
      .msize_o     (msize_o),
      .mwdata_o    (mwdata_o),
      .mack_i      (mack_i),
      .mrdata_i    (mrdata_i),
      .busy_o      (busy_o),
      .err_o       (err_o)
   );
endmodule

// File: tb/tb_desc_dma_seq.sv
`timescale 1ns/1ps
module tb_desc_dma_seq;
   localparam int NCH = 4;
   localparam int AW  = 16;
   localparam int CW  = 8;
   localparam int BASE = 'h100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCH-1:0] trig = '0, trig_hw = '0, en_set = '0;
   logic mreq, mwe, mack = 1'b0, busy, err;
   logic [AW-1:0] maddr;
   logic [1:0] msize;
   logic [31:0] mwdata, mrdata = '0;
   logic [NCH-1:0] flag, en;

   int n_cmp = 0, n_bad = 0;
   logic [7:0]  mem [0:1023];
   logic [15:0] lg_addr [0:63];
   logic        lg_we   [0:63];
   int nlog = 0, hold_viol = 0, err_cnt = 0, busy_cnt = 0;
   logic prev_pend = 1'b0, prev_we = 1'b0;
   logic [AW-1:0] prev_addr = '0;

   always #2.5 clk = ~clk;

   desc_dma_seq #(.NCH(NCH), .AW(AW), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .trig_hw_i(trig_hw), .en_set_i(en_set),
      .base_addr_i(AW'(BASE)), .mreq_o(mreq), .mwe_o(mwe), .maddr_o(maddr),
      .msize_o(msize), .mwdata_o(mwdata), .mack_i(mack), .mrdata_i(mrdata),
      .busy_o(busy), .irq_flag_o(flag), .chan_en_o(en), .err_o(err)
   );

   // memory model: acknowledge one cycle after a request is seen
   always @(posedge clk) begin
      if (prev_pend && (!mreq || maddr != prev_addr || mwe != prev_we)) hold_viol <= hold_viol + 1;
      prev_pend <= mreq && !mack;
      prev_addr <= maddr;
      prev_we   <= mwe;
      if (err) err_cnt <= err_cnt + 1;
      if (busy) busy_cnt <= busy_cnt + 1;
      if (mreq && !mack) begin
         mack <= 1'b1;
         lg_addr[nlog[5:0]] <= 16'(maddr);
         lg_we[nlog[5:0]]   <= mwe;
         nlog <= nlog + 1;
         if (mwe) begin
            mem[maddr[9:0]] <= mwdata[7:0];
            if (msize != 2'b00) mem[10'(maddr[9:0] + 10'd1)] <= mwdata[15:8];
            if (msize[1]) begin
               mem[10'(maddr[9:0] + 10'd2)] <= mwdata[23:16];
               mem[10'(maddr[9:0] + 10'd3)] <= mwdata[31:24];
            end
         end else if (msize == 2'b00)
            mrdata <= {24'h0, mem[maddr[9:0]]};
         else if (msize == 2'b01)
            mrdata <= {16'h0, mem[10'(maddr[9:0] + 10'd1)], mem[maddr[9:0]]};
         else
            mrdata <= {mem[10'(maddr[9:0] + 10'd3)], mem[10'(maddr[9:0] + 10'd2)],
                       mem[10'(maddr[9:0] + 10'd1)], mem[maddr[9:0]]};
      end else mack <= 1'b0;
   end

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic put_w(int a, logic [31:0] v);
      for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
   endtask

   function automatic logic [31:0] get_w(int a);
      return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
   endfunction

   function automatic logic [31:0] mk_w0(int mode, int dint, int size, int cnt);
      return (32'(mode) << 28) | (32'(dint) << 26) | (32'(size) << 24) | 32'(cnt);
   endfunction

   function automatic logic [31:0] mk_ad(int code, int a);
      return (32'(code) << 28) | 32'(a);
   endfunction

   task automatic set_desc(int c, logic [31:0] w0, logic [31:0] w1, logic [31:0] w2);
      put_w(BASE + 12*c, w0);
      put_w(BASE + 12*c + 4, w1);
      put_w(BASE + 12*c + 8, w2);
   endtask

   task automatic fire(logic [NCH-1:0] m, logic [NCH-1:0] hw);
      @(negedge clk);
      nlog = 0; err_cnt = 0; busy_cnt = 0;
      trig = m; trig_hw = hw;
      @(negedge clk);
      trig = '0; trig_hw = '0;
   endtask

   task automatic wait_idle(string r);
      int quiet = 0, t = 0;
      while (quiet < 8 && t < 5000) begin
         @(negedge clk);
         t++;
         quiet = busy ? 0 : quiet + 1;
      end
      if (t >= 5000) chk({r, " timeout"}, 32'(busy), 32'h0);
   endtask

   task automatic t_reset;
      chk("R9 reset busy", 32'(busy), 0);
      chk("R12 reset mreq", 32'(mreq), 0);
      chk("R9 reset flags", 32'(flag), 0);
      chk("R7 reset enables", 32'(en), 32'hF);
      chk("R10 reset err", 32'(err), 0);
   endtask

   task automatic t_word_inc_hw;   // ch1, word, increment, DINTEN=1
      for (int i = 0; i < 3; i++) put_w('h200 + 4*i, 32'hA5000000 + 32'(i * 'h1111));
      set_desc(1, mk_w0(1, 1, 2, 3), mk_ad(1, 'h200), mk_ad(1, 'h280));
      fire(4'b0010, 4'b0010);
      chk("R9 hw flag set", 32'(flag[1]), 1);
      wait_idle("R3");
      chk("R1 load0", 32'(lg_addr[0]), 'h10C);
      chk("R1 load1", 32'(lg_addr[1]), 'h110);
      chk("R1 load2", 32'(lg_addr[2]), 'h114);
      chk("R3 access count", 32'(nlog), 12);
      for (int i = 0; i < 3; i++) chk("R3 word copy", get_w('h280 + 4*i), 32'hA5000000 + 32'(i * 'h1111));
      chk("R5 wb w0", get_w('h10C), mk_w0(1, 1, 2, 0));
      chk("R5 wb src", get_w('h110), mk_ad(1, 'h20C));
      chk("R5 wb dst", get_w('h114), mk_ad(1, 'h28C));
      chk("R7 flag kept", 32'(flag[1]), 1);
      chk("R7 enable cleared", 32'(en[1]), 0);
   endtask

   task automatic t_half_dec_sw;   // ch1 sw, halfword, src decrement, dst fixed
      put_w('h300, 32'h2222_1111);
      put_w('h380, 32'h0);
      set_desc(1, mk_w0(1, 0, 1, 2), mk_ad(2, 'h302), mk_ad(0, 'h380));
      fire(4'b0010, 4'b0000);
      wait_idle("R4");
      chk("R4 src order", 32'(lg_addr[3]), 'h302);
      chk("R4 dec step", 32'(lg_addr[5]), 'h300);
      chk("R4 fixed dst last", get_w('h380), 32'h0000_1111);
      chk("R4 wb src dec", get_w('h110), mk_ad(2, 'h2FE));
      chk("R9 sw flag untouched", 32'(flag[1]), 1);
      chk("R9 sw enable untouched", 32'(en[1]), 0);
   endtask

   task automatic t_byte_hw_nodint; // ch0 hw, byte, DINTEN=0
      for (int i = 0; i < 5; i++) mem['h340 + i] = 8'(8'h30 + i);
      set_desc(0, mk_w0(1, 0, 0, 5), mk_ad(1, 'h340), mk_ad(1, 'h3A0));
      fire(4'b0001, 4'b0001);
      chk("R9 hw flag set ch0", 32'(flag[0]), 1);
      wait_idle("R8");
      for (int i = 0; i < 5; i++) chk("R4 byte copy", 32'(mem['h3A0 + i]), 32'(8'h30 + i));
      chk("R4 byte step dst", get_w('h108), mk_ad(1, 'h3A5));
      chk("R8 flag cleared", 32'(flag[0]), 0);
      chk("R8 enable kept", 32'(en[0]), 1);
   endtask

   task automatic t_zero_count;     // ch3 hw, count 0, DINTEN=1
      set_desc(3, mk_w0(1, 1, 2, 0), mk_ad(1, 'h200), mk_ad(1, 'h3C0));
      fire(4'b1000, 4'b1000);
      wait_idle("R6");
      chk("R6 only load and store", 32'(nlog), 6);
      chk("R6 store follows", 32'({lg_we[3], lg_we[4], lg_we[5]}), 3'b111);
      chk("R6 wb addr", 32'(lg_addr[3]), 'h124);
      chk("R6 completion ran", 32'({flag[3], en[3]}), 2'b10);
   endtask

   task automatic t_bad_mode;       // ch2 sw, mode 10
      set_desc(2, mk_w0(2, 0, 2, 2), mk_ad(1, 'h200), mk_ad(1, 'h3E0));
      fire(4'b0100, 4'b0000);
      wait_idle("R2");
      chk("R2 loads only", 32'(nlog), 3);
      chk("R2 descriptor unchanged", get_w('h118), mk_w0(2, 0, 2, 2));
   endtask

   task automatic t_misalign;       // ch2 sw, word size, src at 0x202
      set_desc(2, mk_w0(1, 0, 2, 2), mk_ad(1, 'h202), mk_ad(1, 'h3E0));
      fire(4'b0100, 4'b0000);
      wait_idle("R10");
      chk("R10 err pulse", 32'(err_cnt), 1);
      chk("R10 no data no store", 32'(nlog), 3);
      chk("R10 flags unchanged", 32'({flag[2], en[2]}), 2'b01);
   endtask

   task automatic t_hw_disabled;    // ch1 enable is clear
      fire(4'b0010, 4'b0010);
      repeat (20) @(negedge clk);
      chk("R9 ignored hw busy", 32'(busy_cnt), 0);
      chk("R9 ignored hw access", 32'(nlog), 0);
      en_set = 4'b0010;
      @(negedge clk);
      en_set = '0;
      chk("R9 enable set", 32'(en[1]), 1);
   endtask

   task automatic t_priority;       // ch0 and ch3 in the same cycle
      set_desc(0, mk_w0(1, 0, 2, 1), mk_ad(1, 'h200), mk_ad(1, 'h3E0));
      set_desc(3, mk_w0(1, 0, 2, 1), mk_ad(1, 'h204), mk_ad(1, 'h3F0));
      fire(4'b1001, 4'b0000);
      wait_idle("R11");
      chk("R11 low channel first", 32'(lg_addr[0]), 'h100);
      chk("R11 high channel next", 32'(lg_addr[8]), 'h124);
      chk("R11 both served", 32'(nlog), 16);
   endtask

   task automatic finish_up;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_word_inc_hw();
      t_half_dec_sw();
      t_byte_hw_nodint();
      t_zero_count();
      t_bad_mode();
      t_misalign();
      t_hw_disabled();
      t_priority();
      chk("R12 request held", 32'(hold_viol), 0);
      finish_up();
   end

   initial begin
      #(5.0 * 200000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end
endmodule